// File: doc/BRIEF.md
# Mirror Transfer Handshake Sequencer

This block lives on the testbench side of a chip-level verification setup. It lets software running inside the chip control an external mirror peripheral. The software reaches it through a byte-wide bank of general-purpose registers on an external memory bus. One control register carries two software-driven wires: a start request and a direction select. One read-only status register returns three mirror-driven wires: a configured flag, a pass flag and a result-valid flag. A third register gives the number of bytes in the transfer.

A rising edge on the start wire moves the sequencer out of idle. The sequencer captures the direction and the byte count, spends a fixed number of cycles configuring the mirror channel, and then raises the configured flag. From that point software may move data. For data the chip sends toward the mirror, the block compares each byte with an incrementing pattern. After the last byte it publishes the pass/fail result. For data the mirror sends toward the chip, the block emits the same incrementing pattern on a valid/ready stream and publishes no result, because the software checks that data. Clearing the start wire ends the transfer and returns the sequencer to idle.

Top module: `mirror_handshake_seq`

## Requirements
- R1: After reset, every register reads 0x00, the status register reads 0x00 and `tx_valid_o` is low.
- R2: Every address other than 1 stores the byte written to it and returns that byte on reads.
- R3: Address 1 is the status register: bit 0 is configured, bit 1 is pass, bit 2 is result-valid, and the upper bits read 0. Writes to address 1 have no effect.
- R4: A 0-to-1 transition of bit 0 of address 0 (start), seen while idle, starts a transfer. The configured flag rises exactly 5 clock edges after the bus write edge: 1 edge to detect the start and 4 configuration cycles.
- R5: Bit 1 of address 0 (direction: 1 = chip to mirror, 0 = mirror to chip) and the count in address 2 are sampled when start is detected. Changing them later has no effect on the running transfer.
- R6: In chip-to-mirror mode, the byte accepted at position k on the `rx_valid_i` stream (k from 0) is compared with k mod 256. After the last of `count` bytes the status register reads 0x07 if every byte matched.
- R7: In chip-to-mirror mode, a single mismatching byte makes the status register read 0x05 after the last byte. Result-valid stays 0 until the last byte is accepted.
- R8: In chip-to-mirror mode with a count of 0, the result is a pass with no bytes, and the status register reads 0x07 one cycle after the configured flag rises.
- R9: In mirror-to-chip mode, once configured, the block presents the bytes 0, 1, … count-1 on `tx_data_o` with `tx_valid_o`. Each byte advances on a cycle where `tx_ready_i` is high, the data holds while the byte is stalled, `tx_valid_o` drops after the last byte, and result-valid stays 0.
- R10: Clearing start in any non-idle state returns the sequencer to idle on the next edge, and the status register reads 0x00. This includes an abort during configuration.
- R11: Writing start = 1 while it is already 1 is not a new start, and a reported result is left unchanged.
- R12: Bytes on `rx_valid_i` outside the receive phase are ignored and do not affect the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 7 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data (combinational on address) |
| rx_valid_i | input | 1 | Byte from chip to mirror is valid |
| rx_data_i | input | 8 | Byte from chip to mirror |
| tx_ready_i | input | 1 | Chip accepts the byte from the mirror |
| tx_valid_o | output | 1 | Mirror byte to chip is valid |
| tx_data_o | output | 8 | Mirror byte to chip |

## Verification
The bench checks the exact edge on which the configured flag rises. A sequencer with the wrong configuration length would raise it one cycle early or late. It places a mismatch at the first byte, at the last byte and in the middle. A comparator that ignored the final byte, or that published its result early, would report pass or set result-valid before the last byte. A zero count, an abort during configuration, a repeated start write while a result is held, and a direction change in mid-transfer are all driven. A design that mishandled any of these would hang in receive, keep the configured flag after an abort, restart and clear its result, or switch stream direction. Random stall patterns on `tx_ready_i` show whether the mirror's outgoing data skips or repeats bytes.

// File: rtl/mhs_pkg.sv
package mhs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONFIG,
    ST_READY,
    ST_RECEIVE,
    ST_REPORT
  } seq_state_e;

  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned STAT_ADDR = 1;
  localparam int unsigned CNT_ADDR  = 2;

  localparam int unsigned START_BIT = 0;
  localparam int unsigned DIR_BIT   = 1;

  localparam int unsigned DONE_BIT  = 0;
  localparam int unsigned PASS_BIT  = 1;
  localparam int unsigned VALID_BIT = 2;
endpackage

// File: rtl/mhs_reg_bank.sv
module mhs_reg_bank
  import mhs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] stat_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] count_o
);
  localparam int unsigned NUM_REGS = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == STAT_ADDR) begin : g_ro
      // status word is wired in from the sequencer, never stored
      assign regs[g] = stat_i;
    end else begin : g_rw
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else if (we_i && addr_i == ADDR_W'(g)) q <= wdata_i;
      end
      assign regs[g] = q;
    end
  end

  assign rdata_o = regs[addr_i];
  assign ctrl_o  = regs[CTRL_ADDR];
  assign count_o = regs[CNT_ADDR];

  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == ADDR_W'(CTRL_ADDR)) |=> $stable(ctrl_o));
endmodule

// File: rtl/mhs_seq.sv
module mhs_seq
  import mhs_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CFG_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dir_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              rx_fin_i,
  input  logic              rx_pass_i,
  output seq_state_e        state_o,
  output logic [DATA_W-1:0] count_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              pass_vld_o
);
  localparam int unsigned CFG_W = $clog2(CFG_CYCLES + 1);

  seq_state_e        state_q;
  logic              start_q, dir_q, pass_q;
  logic [CFG_W-1:0]  cfg_cnt_q;
  logic [DATA_W-1:0] cnt_q;
  logic              start_rise;

  assign start_rise = start_i & ~start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      start_q   <= 1'b0;
      dir_q     <= 1'b0;
      pass_q    <= 1'b0;
      cfg_cnt_q <= '0;
      cnt_q     <= '0;
    end else begin
      start_q <= start_i;
      if (state_q != ST_IDLE && !start_i) begin
        state_q <= ST_IDLE;
        pass_q  <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_rise) begin
            state_q   <= ST_CONFIG;
            cfg_cnt_q <= '0;
            dir_q     <= dir_i;
            cnt_q     <= count_i;
            pass_q    <= 1'b0;
          end
          ST_CONFIG: begin
            if (cfg_cnt_q == CFG_W'(CFG_CYCLES - 1))
              state_q <= dir_q ? ST_RECEIVE : ST_READY;
            else
              cfg_cnt_q <= cfg_cnt_q + 1'b1;
          end
          ST_RECEIVE: if (rx_fin_i) begin
            state_q <= ST_REPORT;
            pass_q  <= rx_pass_i;
          end
          default: ;
        endcase
      end
    end
  end

  assign state_o    = state_q;
  assign count_o    = cnt_q;
  assign done_o     = state_q inside {ST_READY, ST_RECEIVE, ST_REPORT};
  assign pass_vld_o = state_q == ST_REPORT;
  assign pass_o     = pass_q & pass_vld_o;

  p_idle_on_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !start_i) |=> state_q == ST_IDLE);
  p_done_from_cfg_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(state_q) == ST_CONFIG);
  p_result_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REPORT && start_i) |=> (state_q == ST_REPORT && $stable(pass_o)));
endmodule

// File: rtl/mhs_stream.sv
module mhs_stream
  import mhs_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  seq_state_e        state_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_ready_i,
  output logic              rx_fin_o,
  output logic              rx_pass_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic [DATA_W-1:0] idx_q;
  logic              bad_q;
  logic              rx_en, tx_en, clr, rx_hit, rx_miss;

  assign rx_en   = state_i == ST_RECEIVE;
  assign tx_en   = state_i == ST_READY;
  assign clr     = state_i inside {ST_IDLE, ST_CONFIG};
  assign rx_hit  = rx_en & rx_valid_i;
  assign rx_miss = rx_hit & (rx_data_i != idx_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else if (clr) begin
      idx_q <= '0;
      bad_q <= 1'b0;
    end else if (rx_hit) begin
      idx_q <= idx_q + 1'b1;
      if (rx_miss) bad_q <= 1'b1;
    end else if (tx_valid_o && tx_ready_i) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign rx_fin_o   = rx_en & ((count_i == '0) |
                               (rx_hit & (idx_q == count_i - DATA_W'(1))));
  assign rx_pass_o  = ~bad_q & ~rx_miss;
  assign tx_valid_o = tx_en & (idx_q != count_i);
  assign tx_data_o  = idx_q;

  p_tx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (!tx_valid_o || $stable(tx_data_o)));
  p_rx_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_en |-> (count_i == '0 || idx_q < count_i));
endmodule

// File: rtl/mirror_handshake_seq.sv
module mirror_handshake_seq
  import mhs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 7,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CFG_CYCLES = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_ready_i,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o
);
  logic [DATA_W-1:0] ctrl, count_reg, count_lat, stat;
  seq_state_e        state;
  logic              done, pass, pass_vld, rx_fin, rx_pass;

  always_comb begin
    stat            = '0;
    stat[DONE_BIT]  = done;
    stat[PASS_BIT]  = pass;
    stat[VALID_BIT] = pass_vld;
  end

  mhs_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .stat_i  (stat),
    .ctrl_o  (ctrl),
    .count_o (count_reg)
  );

  mhs_seq #(.DATA_W(DATA_W), .CFG_CYCLES(CFG_CYCLES)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (ctrl[START_BIT]),
    .dir_i      (ctrl[DIR_BIT]),
    .count_i    (count_reg),
    .rx_fin_i   (rx_fin),
    .rx_pass_i  (rx_pass),
    .state_o    (state),
    .count_o    (count_lat),
    .done_o     (done),
    .pass_o     (pass),
    .pass_vld_o (pass_vld)
  );

  mhs_stream #(.DATA_W(DATA_W)) i_stream (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .state_i    (state),
    .count_i    (count_lat),
    .rx_valid_i (rx_valid_i),
    .rx_data_i  (rx_data_i),
    .tx_ready_i (tx_ready_i),
    .rx_fin_o   (rx_fin),
    .rx_pass_o  (rx_pass),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o)
  );

  p_valid_needs_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_vld |-> done);
  p_no_tx_while_rx_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> !pass_vld);
endmodule

// File: tb/test_mirror_handshake_seq.sv
module test_mirror_handshake_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic       tx_ready = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  mirror_handshake_seq i_mirror_handshake_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .tx_ready_i(tx_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data)
  );

  function automatic int exp_stat(bit done, bit pass, bit vld);
    return (vld ? 4 : 0) + (pass ? 2 : 0) + (done ? 1 : 0);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    we = 1'b1; addr = a[6:0]; wdata = d[7:0];
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    we = 1'b0; addr = a[6:0];
    #1;
    d = int'(rdata);
  endtask

  task automatic wait_done(string req);
    int d;
    bit seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      rd(1, d);
      if (d[0]) begin
        seen = 1'b1;
        break;
      end
      cyc(1);
    end
    chk(req, int'(seen), 1);
  endtask

  task automatic send_byte(int v);
    rx_valid = 1'b1; rx_data = v[7:0];
    cyc(1);
    rx_valid = 1'b0;
  endtask

  // chip-to-mirror transfer; bad < 0 means no corrupted byte
  task automatic run_rx(int n, int bad, int gap_max);
    int d;
    wr(2, n);
    wr(0, 3);
    wait_done("R4 configured flag");
    for (int i = 0; i < n; i++) begin
      if (gap_max > 0) cyc($urandom % (gap_max + 1));
      if (i == n - 1) begin
        rd(1, d);
        chk("R7 result-valid before last byte", (d >> 2) & 1, 0);
      end
      send_byte(i == bad ? (i ^ 8'h5A) : i);
    end
    rd(1, d);
    chk(bad < 0 ? "R6 pass report" : "R7 fail report", d, exp_stat(1, bad < 0, 1));
    wr(0, 0);
    cyc(1);
    rd(1, d);
    chk("R10 clear after report", d, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int d, k;
    int shadow [128];
    bit used [128];
    void'($urandom(32'd20240611));
    for (int i = 0; i < 128; i++) begin shadow[i] = 0; used[i] = 1'b0; end
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    rd(0, d);  chk("R1 ctrl reset", d, 0);
    rd(1, d);  chk("R1 status reset", d, 0);
    rd(2, d);  chk("R1 count reset", d, 0);
    rd(77, d); chk("R1 general reset", d, 0);
    chk("R1 tx_valid reset", int'(tx_valid), 0);

    // R3 status register is read-only
    wr(1, 8'hFF);
    rd(1, d); chk("R3 write to status ignored", d, 0);

    // R2 random register traffic on general addresses
    for (int i = 0; i < 24; i++) begin
      int a = 3 + int'($urandom % 125);
      int v = int'($urandom % 256);
      wr(a, v);
      shadow[a] = v; used[a] = 1'b1;
    end
    for (int a = 3; a < 128; a++)
      if (used[a]) begin rd(a, d); chk("R2 readback", d, shadow[a]); end

    // R4 exact configuration latency
    wr(2, 1);
    wr(0, 3);
    cyc(4); rd(1, d); chk("R4 not configured after 4 edges", d & 1, 0);
    cyc(1); rd(1, d); chk("R4 configured after 5 edges", d & 1, 1);
    send_byte(0);
    rd(1, d); chk("R6 single byte pass", d, exp_stat(1, 1, 1));
    // R11 repeated start write keeps the result
    wr(0, 3);
    cyc(3);
    rd(1, d); chk("R11 result held", d, exp_stat(1, 1, 1));
    wr(0, 0); cyc(1);
    rd(1, d); chk("R10 clear", d, 0);

    // R8 zero count
    wr(2, 0);
    wr(0, 3);
    wait_done("R8 configured flag");
    cyc(1);
    rd(1, d); chk("R8 zero-count pass", d, exp_stat(1, 1, 1));
    wr(0, 0); cyc(1);

    // R5 direction and count changed after start
    wr(2, 3);
    wr(0, 3);
    wr(2, 9);
    wr(0, 1);
    wait_done("R5 configured flag");
    chk("R5 no mirror stream", int'(tx_valid), 0);
    for (int i = 0; i < 3; i++) send_byte(i);
    rd(1, d); chk("R5 sampled direction and count", d, exp_stat(1, 1, 1));
    wr(0, 0); cyc(1);

    // R10 abort during configuration
    wr(2, 4);
    wr(0, 3);
    cyc(1);
    wr(0, 0);
    cyc(8);
    rd(1, d); chk("R10 abort in config", d, 0);

    // R12 stray bytes while idle
    for (int i = 0; i < 3; i++) send_byte(8'hFF);
    run_rx(3, -1, 0);

    // R7 mismatch at first and last byte
    run_rx(4, 0, 0);
    run_rx(4, 3, 1);

    // R6/R7 constrained random receive runs
    for (int r = 0; r < 10; r++) begin
      int n = 1 + int'($urandom % 20);
      int bad = ($urandom % 3 == 0) ? int'($urandom % n) : -1;
      run_rx(n, bad, 2);
    end

    // R9 mirror-to-chip stream with random stalls
    for (int r = 0; r < 3; r++) begin
      int n = 2 + int'($urandom % 10);
      wr(2, n);
      wr(0, 1);
      wait_done("R9 configured flag");
      k = 0;
      for (int c = 0; c < 200 && k < n; c++) begin
        tx_ready = 1'($urandom % 2);
        #1;
        if (tx_valid && tx_ready) begin
          chk("R9 mirror byte", int'(tx_data), k);
          k++;
        end
        cyc(1);
      end
      tx_ready = 1'b0;
      chk("R9 byte count", k, n);
      cyc(2);
      chk("R9 valid drops after last", int'(tx_valid), 0);
      rd(1, d); chk("R9 no result published", d, exp_stat(1, 0, 0));
      wr(0, 0); cyc(1);
      rd(1, d); chk("R10 clear after send", d, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule